// File: doc/BRIEF.md
# Register Rename Map Table

This block is the register alias table of an out-of-order core's rename stage. It keeps one map table for integer architectural registers and one for floating-point architectural registers. Each entry holds the physical register that currently stands for the architectural one. A third, miscellaneous class is never renamed: every miscellaneous register keeps a fixed physical index equal to its class-relative index. A unified architectural index enters the block and is decoded into a class and a class-relative index. Integer indices come first, floating-point indices next, miscellaneous indices after those. Any higher value belongs to no class.

Three operations are offered, and they may all occur in the same cycle on separate ports. A rename allocates a new physical register and reports both the new and the previous mapping. A lookup reads the current mapping combinationally. A set writes any physical index into a map entry, which is how commit and squash recovery put the table back in order.

Each renamed class draws its new physical registers from its own external free list through a pop handshake. The free list presents its head register and an empty flag, and the block raises a pop strobe in the cycle it takes that head. Each class has a zero register, chosen by parameter, that is never renamed and consumes no free-list entry.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, integer register i maps to physical i, floating-point register i maps to physical i, and miscellaneous register i reads as physical i. res_valid and all error flags are 0.
- R2: A rename of a non-zero integer or floating-point register is accepted when ren_valid and ren_ready are both 1. In that cycle it pops the class's free list and writes the head register into the map. One cycle later it shows res_valid=1, res_new equal to that head register and res_prev equal to the mapping held before the rename.
- R3: A rename of a class's zero register pops nothing and leaves the map unchanged. ren_ready is 1 even when the class's free list is empty. One cycle later res_new equals the zero index and res_prev equals the entry's current value.
- R4: When a zero-register rename finds an entry that does not hold the zero index, err_zero is 1 for the one cycle in which its result is shown.
- R5: Integer and floating-point registers use separate tables and separate free lists. A rename in one class never pops the other class's list and never changes the other class's mappings.
- R6: Unified indices decode as follows: 0 to INT_N-1 are integer, the next FP_N are floating-point and the next MISC_N are miscellaneous. The class-relative index is the unified index minus the first index of its class. With the defaults, integer is 0..7, floating-point is 8..15, miscellaneous is 16..19, and 20..31 belong to no class.
- R7: A miscellaneous rename pops nothing and returns res_new = res_prev = its relative index. A set to a miscellaneous register leaves the mapping unchanged. If the set carries any value other than the relative index, err_misc is 1 in the next cycle.
- R8: An index of no class gives lk_err=1 on lookup. A rename or set with such an index pops nothing, writes nothing and gives no res_valid, and err_unknown is 1 in the next cycle.
- R9: While a non-zero integer or floating-point rename waits on an empty free list, ren_ready is 0. During that wait there is no pop and no map write.
- R10: A set to an integer or floating-point register writes set_phys into the entry, and lookup returns that value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | IDX_W | Unified architectural index to rename |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| res_valid | output | 1 | Registered rename result valid |
| res_new | output | PHYS_W | Newly assigned physical register |
| res_prev | output | PHYS_W | Physical register held before the rename |
| lk_arch | input | IDX_W | Unified index to look up |
| lk_phys | output | PHYS_W | Current mapping (combinational) |
| lk_err | output | 1 | Lookup index belongs to no class |
| set_valid | input | 1 | Set request |
| set_arch | input | IDX_W | Unified index to overwrite |
| set_phys | input | PHYS_W | Physical index to write |
| int_free_empty | input | 1 | Integer free list has no register |
| int_free_reg | input | PHYS_W | Integer free list head |
| int_pop | output | 1 | Take the integer free list head |
| fp_free_empty | input | 1 | Floating-point free list has no register |
| fp_free_reg | input | PHYS_W | Floating-point free list head |
| fp_pop | output | 1 | Take the floating-point free list head |
| err_zero | output | 1 | Zero register held a non-zero mapping |
| err_misc | output | 1 | Miscellaneous set carried a wrong value |
| err_unknown | output | 1 | Rename or set to an index of no class |

## Verification
A corrupt map entry stays hidden until that entry is read. It then shows as a wrong lk_phys in the same cycle, or as a wrong res_prev one cycle after the next rename of that register. A mistake in the class decode shows up at once as a pop on the wrong free list, or as a lookup answering from the wrong table at a class boundary. A faulty stall or zero-register test appears as a pop count that drifts away from the number of renames: the next head register handed out is then wrong, and the following res_new exposes it.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2,
    CLS_NONE = 2'd3
  } rat_cls_e;
endpackage

// File: rtl/rat_idx_decode.sv
module rat_idx_decode
  import rat_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int INT_N  = 8,
  parameter int FP_N   = 8,
  parameter int MISC_N = 4
) (
  input  logic [IDX_W-1:0] arch,
  output rat_cls_e         cls,
  output logic [IDX_W-1:0] rel
);
  localparam logic [31:0] FP_BASE   = 32'(INT_N);
  localparam logic [31:0] MISC_BASE = 32'(INT_N + FP_N);
  localparam logic [31:0] END_IDX   = 32'(INT_N + FP_N + MISC_N);

  logic [31:0] au;
  assign au = 32'(arch);

  always_comb begin
    if (au < FP_BASE) begin
      cls = CLS_INT;
      rel = arch;
    end else if (au < MISC_BASE) begin
      cls = CLS_FP;
      rel = IDX_W'(au - FP_BASE);
    end else if (au < END_IDX) begin
      cls = CLS_MISC;
      rel = IDX_W'(au - MISC_BASE);
    end else begin
      cls = CLS_NONE;
      rel = '0;
    end
  end
endmodule

// File: rtl/rat_class_map.sv
module rat_class_map #(
  parameter int ARCH_N = 8,
  parameter int IDX_W  = 5,
  parameter int PHYS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [PHYS_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [PHYS_W-1:0] lk_data,
  input  logic              rw_en,
  input  logic [IDX_W-1:0]  rw_idx,
  input  logic [PHYS_W-1:0] rw_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [PHYS_W-1:0] sw_data
);
  localparam int AW = (ARCH_N > 1) ? $clog2(ARCH_N) : 1;

  logic [PHYS_W-1:0] map_q [ARCH_N];

  function automatic logic in_rng(input logic [IDX_W-1:0] i);
    return 32'(i) < 32'(ARCH_N);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PHYS_W'(i);
    end else begin
      if (sw_en && in_rng(sw_idx)) map_q[sw_idx[AW-1:0]] <= sw_data;
      if (rw_en && in_rng(rw_idx)) map_q[rw_idx[AW-1:0]] <= rw_data;
    end
  end

  assign rd_data = in_rng(rd_idx) ? map_q[rd_idx[AW-1:0]] : '0;
  assign lk_data = in_rng(lk_idx) ? map_q[lk_idx[AW-1:0]] : '0;
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
  import rat_pkg::*;
#(
  parameter int INT_N    = 8,
  parameter int FP_N     = 8,
  parameter int MISC_N   = 4,
  parameter int IDX_W    = 5,
  parameter int PHYS_W   = 5,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_valid,
  input  logic [IDX_W-1:0]  ren_arch,
  output logic              ren_ready,
  output logic              res_valid,
  output logic [PHYS_W-1:0] res_new,
  output logic [PHYS_W-1:0] res_prev,
  input  logic [IDX_W-1:0]  lk_arch,
  output logic [PHYS_W-1:0] lk_phys,
  output logic              lk_err,
  input  logic              set_valid,
  input  logic [IDX_W-1:0]  set_arch,
  input  logic [PHYS_W-1:0] set_phys,
  input  logic              int_free_empty,
  input  logic [PHYS_W-1:0] int_free_reg,
  output logic              int_pop,
  input  logic              fp_free_empty,
  input  logic [PHYS_W-1:0] fp_free_reg,
  output logic              fp_pop,
  output logic              err_zero,
  output logic              err_misc,
  output logic              err_unknown
);
  localparam logic [IDX_W-1:0]  INT_Z_IDX  = IDX_W'(INT_ZERO);
  localparam logic [IDX_W-1:0]  FP_Z_IDX   = IDX_W'(FP_ZERO);
  localparam logic [PHYS_W-1:0] INT_Z_PHYS = PHYS_W'(INT_ZERO);
  localparam logic [PHYS_W-1:0] FP_Z_PHYS  = PHYS_W'(FP_ZERO);

  rat_cls_e ren_cls, lk_cls, set_cls;
  logic [IDX_W-1:0] ren_rel, lk_rel, set_rel;

  rat_idx_decode #(.IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .MISC_N(MISC_N))
    u_dec_ren (.arch(ren_arch), .cls(ren_cls), .rel(ren_rel));
  rat_idx_decode #(.IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .MISC_N(MISC_N))
    u_dec_lk  (.arch(lk_arch),  .cls(lk_cls),  .rel(lk_rel));
  rat_idx_decode #(.IDX_W(IDX_W), .INT_N(INT_N), .FP_N(FP_N), .MISC_N(MISC_N))
    u_dec_set (.arch(set_arch), .cls(set_cls), .rel(set_rel));

  logic is_int, is_fp, is_zero, need_pop, accept;
  assign is_int   = (ren_cls == CLS_INT);
  assign is_fp    = (ren_cls == CLS_FP);
  assign is_zero  = (is_int && ren_rel == INT_Z_IDX) || (is_fp && ren_rel == FP_Z_IDX);
  assign need_pop = (is_int || is_fp) && !is_zero;

  assign ren_ready = !(need_pop && ((is_int && int_free_empty) || (is_fp && fp_free_empty)));
  assign accept    = ren_valid && ren_ready;
  assign int_pop   = accept && need_pop && is_int;
  assign fp_pop    = accept && need_pop && is_fp;

  logic [PHYS_W-1:0] int_rd, int_lk, fp_rd, fp_lk;

  rat_class_map #(.ARCH_N(INT_N), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_int_map (
    .clk, .rst,
    .rd_idx(ren_rel), .rd_data(int_rd),
    .lk_idx(lk_rel),  .lk_data(int_lk),
    .rw_en(int_pop),  .rw_idx(ren_rel), .rw_data(int_free_reg),
    .sw_en(set_valid && set_cls == CLS_INT), .sw_idx(set_rel), .sw_data(set_phys)
  );

  rat_class_map #(.ARCH_N(FP_N), .IDX_W(IDX_W), .PHYS_W(PHYS_W)) u_fp_map (
    .clk, .rst,
    .rd_idx(ren_rel), .rd_data(fp_rd),
    .lk_idx(lk_rel),  .lk_data(fp_lk),
    .rw_en(fp_pop),   .rw_idx(ren_rel), .rw_data(fp_free_reg),
    .sw_en(set_valid && set_cls == CLS_FP), .sw_idx(set_rel), .sw_data(set_phys)
  );

  logic [PHYS_W-1:0] prev_c, new_c, zero_c;
  always_comb begin
    prev_c = '0;
    new_c  = '0;
    zero_c = '0;
    unique case (ren_cls)
      CLS_INT: begin
        prev_c = int_rd;
        zero_c = INT_Z_PHYS;
        new_c  = is_zero ? INT_Z_PHYS : int_free_reg;
      end
      CLS_FP: begin
        prev_c = fp_rd;
        zero_c = FP_Z_PHYS;
        new_c  = is_zero ? FP_Z_PHYS : fp_free_reg;
      end
      CLS_MISC: begin
        prev_c = PHYS_W'(ren_rel);
        new_c  = PHYS_W'(ren_rel);
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (lk_cls)
      CLS_INT:  lk_phys = int_lk;
      CLS_FP:   lk_phys = fp_lk;
      CLS_MISC: lk_phys = PHYS_W'(lk_rel);
      default:  lk_phys = '0;
    endcase
  end
  assign lk_err = (lk_cls == CLS_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_new     <= '0;
      res_prev    <= '0;
      err_zero    <= 1'b0;
      err_misc    <= 1'b0;
      err_unknown <= 1'b0;
    end else begin
      res_valid   <= accept && (ren_cls != CLS_NONE);
      if (accept) begin
        res_new  <= new_c;
        res_prev <= prev_c;
      end
      err_zero    <= accept && is_zero && (prev_c != zero_c);
      err_misc    <= set_valid && (set_cls == CLS_MISC) && (set_phys != PHYS_W'(set_rel));
      err_unknown <= (ren_valid && ren_cls == CLS_NONE) || (set_valid && set_cls == CLS_NONE);
    end
  end
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int INT_N    = 8,
  parameter int FP_N     = 8,
  parameter int MISC_N   = 4,
  parameter int IDX_W    = 5,
  parameter int PHYS_W   = 5,
  parameter int INT_ZERO = 0,
  parameter int FP_ZERO  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              ren_valid,
  input logic [IDX_W-1:0]  ren_arch,
  input logic              ren_ready,
  input logic              res_valid,
  input logic [PHYS_W-1:0] res_new,
  input logic              int_free_empty,
  input logic              int_pop,
  input logic              fp_free_empty,
  input logic              fp_pop,
  input logic              err_unknown
);
  localparam logic [31:0] MISC_LO = 32'(INT_N + FP_N);
  localparam logic [31:0] TOTAL   = 32'(INT_N + FP_N + MISC_N);

  logic [31:0] au;
  assign au = 32'(ren_arch);

  p_res_from_accept_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(ren_valid && ren_ready));

  p_int_pop_not_empty_r9: assert property (@(posedge clk) disable iff (rst)
    int_pop |-> !int_free_empty);

  p_fp_pop_not_empty_r9: assert property (@(posedge clk) disable iff (rst)
    fp_pop |-> !fp_free_empty);

  p_stall_no_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && !ren_ready) |-> (!int_pop && !fp_pop));

  p_one_class_pop_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_pop, fp_pop}));

  p_int_zero_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && au == 32'(INT_ZERO)) |-> (ren_ready && !int_pop && !fp_pop));

  p_int_zero_result_r3: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_ready && au == 32'(INT_ZERO)) |=> (res_valid && res_new == PHYS_W'(INT_ZERO)));

  p_misc_no_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && au >= MISC_LO && au < TOTAL) |-> (ren_ready && !int_pop && !fp_pop));

  p_unknown_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && au >= TOTAL) |-> (!int_pop && !fp_pop));

  p_unknown_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && au >= TOTAL) |=> (err_unknown && !res_valid));

  p_fp_zero_no_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && au == 32'(INT_N + FP_ZERO)) |-> !fp_pop);
endmodule

bind rename_alias_table rat_checker #(
  .INT_N(INT_N), .FP_N(FP_N), .MISC_N(MISC_N), .IDX_W(IDX_W),
  .PHYS_W(PHYS_W), .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO)
) u_chk (
  .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_arch(ren_arch),
  .ren_ready(ren_ready), .res_valid(res_valid), .res_new(res_new),
  .int_free_empty(int_free_empty), .int_pop(int_pop),
  .fp_free_empty(fp_free_empty), .fp_pop(fp_pop), .err_unknown(err_unknown)
);

// File: tb/rename_alias_table_tb.sv
module rename_alias_table_tb;
  localparam int CLK_P  = 10;
  localparam int IDX_W  = 5;
  localparam int PHYS_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ren_valid = 1'b0;
  logic [IDX_W-1:0] ren_arch = '0;
  logic ren_ready, res_valid, lk_err, int_pop, fp_pop;
  logic [PHYS_W-1:0] res_new, res_prev, lk_phys;
  logic [IDX_W-1:0] lk_arch = '0;
  logic set_valid = 1'b0;
  logic [IDX_W-1:0] set_arch = '0;
  logic [PHYS_W-1:0] set_phys = '0;
  logic err_zero, err_misc, err_unknown;

  // Free-list models: heads hand out 8, 9, 10, ... per class
  int int_head = 0;
  int fp_head  = 0;
  logic force_int_empty = 1'b0;
  logic int_free_empty, fp_free_empty;
  logic [PHYS_W-1:0] int_free_reg, fp_free_reg;
  assign int_free_empty = force_int_empty || (int_head >= 8);
  assign fp_free_empty  = (fp_head >= 8);
  assign int_free_reg   = PHYS_W'(8 + int_head);
  assign fp_free_reg    = PHYS_W'(8 + fp_head);

  always @(posedge clk) begin
    if (int_pop) int_head <= int_head + 1;
    if (fp_pop)  fp_head  <= fp_head + 1;
  end

  always #(CLK_P/2) clk = ~clk;

  rename_alias_table u_dut (
    .clk, .rst, .ren_valid, .ren_arch, .ren_ready, .res_valid, .res_new, .res_prev,
    .lk_arch, .lk_phys, .lk_err, .set_valid, .set_arch, .set_phys,
    .int_free_empty, .int_free_reg, .int_pop, .fp_free_empty, .fp_free_reg, .fp_pop,
    .err_zero, .err_misc, .err_unknown
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input int arch, input int exp, input string tag);
    lk_arch = IDX_W'(arch);
    #1;
    check(tag, int'(lk_phys), exp);
  endtask

  task automatic do_rename(input int arch, input int vld, input int enew, input int eprev,
                           input string tag);
    @(negedge clk);
    ren_valid = 1'b1;
    ren_arch  = IDX_W'(arch);
    @(negedge clk);
    ren_valid = 1'b0;
    check({tag, " valid"}, int'(res_valid), vld);
    if (vld != 0) begin
      check({tag, " new"},  int'(res_new),  enew);
      check({tag, " prev"}, int'(res_prev), eprev);
    end
  endtask

  task automatic do_set(input int arch, input int phys);
    @(negedge clk);
    set_valid = 1'b1;
    set_arch  = IDX_W'(arch);
    set_phys  = PHYS_W'(phys);
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  // {arch, expected new, expected prev}
  localparam logic [14:0] VEC [8] = '{
    {5'd3,  5'd8,  5'd3},   // R2 int
    {5'd3,  5'd9,  5'd8},   // R2 prev is the last rename
    {5'd9,  5'd8,  5'd1},   // R5 fp list is separate
    {5'd0,  5'd0,  5'd0},   // R3 int zero
    {5'd8,  5'd0,  5'd0},   // R3 fp zero
    {5'd17, 5'd1,  5'd1},   // R7 misc fixed
    {5'd7,  5'd10, 5'd7},   // R6 last int index
    {5'd15, 5'd9,  5'd7}    // R6 last fp index
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 res_valid", int'(res_valid), 0);
    check("R1 err flags", int'({err_zero, err_misc, err_unknown}), 0);
    look(5, 5, "R1 int 5");
    look(10, 2, "R1 fp rel 2");
    look(18, 2, "R1 misc rel 2");

    for (int i = 0; i < 8; i++)
      do_rename(int'(VEC[i][14:10]), 1, int'(VEC[i][9:5]), int'(VEC[i][4:0]), "R2/R3/R5 table");

    look(3, 9, "R2 map holds new");
    look(9, 8, "R5 fp map");
    look(11, 3, "R5 fp untouched");
    look(0, 0, "R3 zero unchanged");
    check("R3 int pops", int_head, 3);
    check("R5 fp pops", fp_head, 2);
    // R6 class boundaries
    look(7, 10, "R6 idx 7 int");
    look(15, 9, "R6 idx 15 fp");
    look(16, 0, "R6 idx 16 misc");
    look(19, 3, "R6 idx 19 misc");
    check("R6 idx 19 lk_err", int'(lk_err), 0);
    lk_arch = 5'd20; #1;
    check("R8 idx 20 lk_err", int'(lk_err), 1);

    // R9 stall on empty list
    @(negedge clk);
    force_int_empty = 1'b1;
    ren_valid = 1'b1;
    ren_arch  = 5'd4;
    #1;
    check("R9 ready low", int'(ren_ready), 0);
    @(negedge clk);
    check("R9 no result", int'(res_valid), 0);
    look(4, 4, "R9 no map write");
    check("R9 no pop", int_head, 3);
    force_int_empty = 1'b0;
    #1;
    check("R9 ready back", int'(ren_ready), 1);
    @(negedge clk);
    ren_valid = 1'b0;
    check("R9 result", int'(res_new), 11);
    check("R9 prev", int'(res_prev), 4);

    // R3 zero register ready even when empty
    @(negedge clk);
    force_int_empty = 1'b1;
    ren_valid = 1'b1;
    ren_arch  = 5'd0;
    #1;
    check("R3 zero ready on empty", int'(ren_ready), 1);
    @(negedge clk);
    ren_valid = 1'b0;
    force_int_empty = 1'b0;
    check("R3 zero new", int'(res_new), 0);
    check("R3 no pop", int_head, 4);

    // R10 set then rename sees it
    do_set(5, 20);
    look(5, 20, "R10 set int");
    do_set(12, 17);
    look(12, 17, "R10 set fp");
    do_rename(5, 1, 12, 20, "R10 rename after set");

    // R4 zero entry corrupted by set
    do_set(0, 6);
    do_rename(0, 1, 0, 6, "R4 zero rename");
    check("R4 err_zero", int'(err_zero), 1);
    check("R4 no pop", int_head, 5);
    do_set(0, 0);
    do_rename(0, 1, 0, 0, "R4 clean zero");
    check("R4 err_zero clear", int'(err_zero), 0);

    // R7 misc set
    do_set(18, 2);
    check("R7 matching set", int'(err_misc), 0);
    do_set(18, 9);
    check("R7 mismatch set", int'(err_misc), 1);
    look(18, 2, "R7 misc unchanged");

    // R8 unknown index
    do_rename(25, 0, 0, 0, "R8 unknown rename");
    check("R8 err_unknown ren", int'(err_unknown), 1);
    check("R8 no int pop", int_head, 5);
    check("R8 no fp pop", fp_head, 2);
    do_set(30, 3);
    check("R8 err_unknown set", int'(err_unknown), 1);
    lk_arch = 5'd25; #1;
    check("R8 lk_err", int'(lk_err), 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule